// File: doc/BRIEF.md
# Wrapping Burst Line-Fill Sequencer

After a cache miss, this block produces the word indices that fill one cache line of four words from main memory. It begins at the word that missed, so the critical word reaches the CPU first. It then steps through the other three words of the same line and wraps at the line boundary, so every fill writes the same four words. The step direction comes from the parity of the missed word address. An even address counts upward and an odd address counts downward.

Main memory delivers words as a stream. Each word that arrives is written into the line buffer at the current index, and the CPU gets a ready strobe in that same cycle. The memory side uses a valid/ready pair. `mem_ready` is high for the whole time a fill is in progress. A word is taken only in a cycle where `mem_valid` and `mem_ready` are both high. When `mem_valid` is low, the sequencer holds its position, so memory can stall for any number of cycles between words. When `mem_ready` is low, any `mem_valid` has no effect. A start request made while a fill is running is dropped.

Top module: `lf_line_fill_seq`

## Requirements
- R1: When `start` is high and no fill is in progress, the block captures `miss_addr` (a word address). `mem_ready` is high from the next cycle.
- R2: The first word taken has `word_idx` equal to `miss_addr[1:0]`. `fill_addr` is always the captured line address (`miss_addr[31:2]`) with `word_idx` in bits [1:0].
- R3: If `miss_addr[0]` is 0, each later word index is the previous one plus 1, modulo 4.
- R4: If `miss_addr[0]` is 1, each later word index is the previous one minus 1, modulo 4.
- R5: A fill takes exactly four words, all in one line and all different. After the fourth word, `mem_ready` is low.
- R6: In a cycle where `mem_ready` is high and `mem_valid` is low, `fill_we` and `cpu_ready` are low, and `word_idx` does not change.
- R7: `fill_we` and `cpu_ready` are high in exactly the cycles where `mem_valid` and `mem_ready` are both high. While idle, `mem_valid` causes no write.
- R8: `done` is high for exactly one cycle, the cycle after the fourth write. A `start` in that cycle is accepted.
- R9: A `start` while `mem_ready` is high is ignored. The running fill keeps its line, direction and order.
- R10: After reset, `mem_ready`, `done`, `fill_we` and `cpu_ready` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a line fill |
| miss_addr | input | 32 | Word address that missed |
| mem_valid | input | 1 | Memory word available |
| mem_ready | output | 1 | Fill in progress, words accepted |
| fill_we | output | 1 | Line-buffer write enable |
| cpu_ready | output | 1 | Ready strobe to the CPU for the current word |
| word_idx | output | 2 | Word index within the line |
| fill_addr | output | 32 | Full word address being filled |
| done | output | 1 | One-cycle pulse after the last word |

## Verification
`fill_we`, `cpu_ready`, `word_idx` and `fill_addr` are combinational from the current state and `mem_valid`. The bench drives each word after a falling edge and checks these outputs in that same cycle, before the next rising edge. `mem_ready` rises one cycle after the accepted `start`, and `done` rises one cycle after the fourth word. The bench checks both at the falling edge that follows the registering rising edge. It then checks on the next cycle that `done` has dropped again.

// File: rtl/lf_pkg.sv
package lf_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} lf_dir_e;
endpackage

// File: rtl/lf_wrap_ctr.sv
module lf_wrap_ctr #(
  parameter int W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [W-1:0]    load_val,
  input  lf_pkg::lf_dir_e dir,
  input  logic            adv,
  output logic [W-1:0]    idx
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)        idx <= '0;
    else if (load)     idx <= load_val;
    else if (adv)      idx <= (dir == lf_pkg::DIR_DOWN) ? idx - ONE : idx + ONE;
  end

  // R3: upward step wraps modulo line size
  assert_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && dir == lf_pkg::DIR_UP) |=> idx == W'($past(idx) + ONE));
  // R4: downward step wraps modulo line size
  assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && dir == lf_pkg::DIR_DOWN) |=> idx == W'($past(idx) - ONE));
  // R6: no advance, no change
  assert_idx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(idx));
endmodule

// File: rtl/lf_beat_ctr.sv
module lf_beat_ctr #(
  parameter int BEATS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic last
);
  localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CW-1:0] LAST_V = CW'(BEATS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (adv)    cnt <= (cnt == LAST_V) ? '0 : cnt + CW'(1);
  end

  assign last = (cnt == LAST_V);
endmodule

// File: rtl/lf_line_fill_seq.sv
module lf_line_fill_seq #(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              mem_valid,
  output logic              mem_ready,
  output logic              fill_we,
  output logic              cpu_ready,
  output logic [$clog2(LINE_WORDS)-1:0] word_idx,
  output logic [ADDR_W-1:0] fill_addr,
  output logic              done
);
  import lf_pkg::*;
  localparam int IDX_W  = $clog2(LINE_WORDS);
  localparam int LINE_W = ADDR_W - IDX_W;

  logic              busy, done_q, accept, beat, last;
  logic [LINE_W-1:0] line_q;
  lf_dir_e           dir_q;

  assign accept = start && !busy;
  assign beat   = busy && mem_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done_q <= 1'b0;
      line_q <= '0;
      dir_q  <= DIR_UP;
    end else begin
      done_q <= beat && last;
      if (accept) begin
        busy   <= 1'b1;
        line_q <= miss_addr[ADDR_W-1:IDX_W];
        dir_q  <= miss_addr[0] ? DIR_DOWN : DIR_UP;
      end else if (beat && last) begin
        busy <= 1'b0;
      end
    end
  end

  lf_wrap_ctr #(.W(IDX_W)) u_wrap (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .load_val(miss_addr[IDX_W-1:0]), .dir(dir_q), .adv(beat), .idx(word_idx)
  );

  lf_beat_ctr #(.BEATS(LINE_WORDS)) u_beats (
    .clk(clk), .rst_n(rst_n), .clr(accept), .adv(beat), .last(last)
  );

  assign mem_ready = busy;
  assign fill_we   = beat;
  assign cpu_ready = beat;
  assign fill_addr = {line_q, word_idx};
  assign done      = done_q;

  // R8: done is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: final write is followed by done and an idle port
  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we && last) |=> (done && !mem_ready));
  // R2: first index after acceptance is the missed word
  assert_crit_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> word_idx == $past(miss_addr[IDX_W-1:0]));
  // R9: a request during a fill leaves the line untouched
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mem_ready) |=> $stable(fill_addr[ADDR_W-1:IDX_W]));
endmodule

// File: tb/sim_lf_line_fill_seq.sv
module sim_lf_line_fill_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] miss_addr = '0;
  logic        mem_valid = 1'b0;
  logic        mem_ready, fill_we, cpu_ready, done;
  logic [1:0]  word_idx;
  logic [31:0] fill_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lf_line_fill_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .miss_addr(miss_addr),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .fill_we(fill_we),
    .cpu_ready(cpu_ready), .word_idx(word_idx), .fill_addr(fill_addr), .done(done)
  );

  // vector: miss address, expected order {w0,w1,w2,w3}, stall cycles before each word
  localparam int NV = 8;
  localparam logic [31:0] V_ADDR [NV] = '{32'h0000_0100, 32'h0000_0101, 32'h0000_0102,
    32'h0000_0103, 32'hFFFF_FFF0, 32'h1234_5677, 32'h0000_0ABA, 32'h8000_0005};
  localparam logic [7:0]  V_SEQ  [NV] = '{8'h1B, 8'h4E, 8'hB1, 8'hE4, 8'h1B, 8'hE4, 8'hB1, 8'h4E};
  localparam logic [7:0]  V_GAP  [NV] = '{8'h00, 8'h00, 8'h44, 8'h1B, 8'h20, 8'h03, 8'hFF, 8'h10};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [31:0] a);
    @(negedge clk);
    start = 1'b1; miss_addr = a;
    @(negedge clk);
    start = 1'b0;
    chk(mem_ready == 1'b1, "R1 mem_ready after start", {31'd0, mem_ready}, 32'd1);
  endtask

  // one word: optional stall cycles, then a beat checked in-cycle
  task automatic do_beat(input logic [31:0] a, input logic [1:0] exp_idx, input int stalls);
    for (int s = 0; s < stalls; s++) begin
      mem_valid = 1'b0;
      #1;
      chk(!fill_we && !cpu_ready, "R6 stall no write", {31'd0, fill_we}, 32'd0);
      chk(word_idx == exp_idx, "R6 index held in stall", {30'd0, word_idx}, {30'd0, exp_idx});
      @(negedge clk);
    end
    mem_valid = 1'b1;
    #1;
    chk(fill_we && cpu_ready, "R7 write and ready on beat", {30'd0, fill_we, cpu_ready}, 32'd3);
    chk(word_idx == exp_idx, "R3/R4 word order", {30'd0, word_idx}, {30'd0, exp_idx});
    chk(fill_addr == {a[31:2], exp_idx}, "R2 fill address", fill_addr, {a[31:2], exp_idx});
    @(negedge clk);
    mem_valid = 1'b0;
  endtask

  task automatic check_done(input bit expect_again_start);
    #1;
    chk(done == 1'b1, "R8 done after fourth word", {31'd0, done}, 32'd1);
    chk(mem_ready == 1'b0, "R5 idle after four words", {31'd0, mem_ready}, 32'd0);
    if (!expect_again_start) begin
      @(negedge clk);
      #1;
      chk(done == 1'b0, "R8 done one cycle", {31'd0, done}, 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    mem_valid = 1'b1;
    #1;
    // R10 reset state, R7 idle valid ignored
    chk(!mem_ready && !done, "R10 reset idle", {30'd0, mem_ready, done}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!fill_we && !cpu_ready, "R7 no write while idle", {30'd0, fill_we, cpu_ready}, 32'd0);
    mem_valid = 1'b0;

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      do_start(V_ADDR[v]);
      for (int k = 0; k < 4; k++) begin
        logic [1:0] e;
        e = V_SEQ[v][7-2*k -: 2];
        do_beat(V_ADDR[v], e, int'(V_GAP[v][7-2*k -: 2]));
      end
      check_done(1'b0);
    end

    // R9: start mid-fill is ignored
    do_start(32'h0000_0040);
    do_beat(32'h0000_0040, 2'd0, 0);
    do_beat(32'h0000_0040, 2'd1, 0);
    start = 1'b1; miss_addr = 32'h0000_0057;
    do_beat(32'h0000_0040, 2'd2, 0);
    start = 1'b0;
    chk(mem_ready == 1'b1, "R9 still busy with old fill", {31'd0, mem_ready}, 32'd1);
    do_beat(32'h0000_0040, 2'd3, 0);
    #1;
    chk(done == 1'b1, "R9 old fill completes", {31'd0, done}, 32'd1);

    // R8: start in the done cycle is accepted (odd -> down from 3)
    start = 1'b1; miss_addr = 32'h0000_0023;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(mem_ready == 1'b1 && done == 1'b0, "R8 start accepted on done", {30'd0, mem_ready, done}, 32'd2);
    do_beat(32'h0000_0023, 2'd3, 0);
    do_beat(32'h0000_0023, 2'd2, 1);
    do_beat(32'h0000_0023, 2'd1, 0);
    do_beat(32'h0000_0023, 2'd0, 2);
    check_done(1'b0);

    // R7: valid after completion causes no write
    mem_valid = 1'b1;
    #1;
    chk(!fill_we, "R7 no write after done", {31'd0, fill_we}, 32'd0);
    mem_valid = 1'b0;

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule